// File: doc/BRIEF.md
# ECC Check-Bit Error Injector

This unit sits in the write path of a memory controller. Its job is to corrupt outgoing ECC check bits on purpose, so that the error detection and correction logic further down can be exercised. Software loads a 32-bit flip pattern first. It then writes a small control word that arms injection, chooses which 32-byte half (or halves) of a cacheline gets corrupted, and can also arm a command/address parity fault.

Each cacheline travels as two beats, one for the lower half and one for the upper half. Every beat carries 32 check bits and a parity bit. A beat qualifies when the write-valid strobe and the external address-match flag are both high in the same cycle. The corruption itself is combinational: a qualifying beat leaves the block in the same cycle it arrives.

Once an injection has been done, the arm bits clear themselves, unless repeat mode is on. The flip pattern is made of 8-bit symbol pairs. Flips that stay inside one pair (bits 15:0, or bits 31:16) produce a correctable error. Flips that touch both pairs produce an uncorrectable one.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, both registers read 0, and every beat passes through with its check bits and parity unchanged.
- R2: A write at offset F8h loads the 32-bit flip pattern. A write at offset FCh loads the control word: bit 0 repeat, bits 2:1 half select, bit 3 ECC arm, bit 4 parity arm. Reads at those offsets return the current values, with the unused control bits reading 0. Any other offset reads 0, and a write there changes neither register.
- R3: Check bits pass through unchanged unless the ECC arm bit is 1 and the beat qualifies (write-valid and address-match both high).
- R4: On a qualifying beat with ECC armed, the outgoing check bits equal the incoming ones XOR the flip pattern when the half select covers that beat. The half select values are: 01 covers the lower beat, 10 the upper beat, 11 both beats, and 00 no beat.
- R5: With repeat off, the ECC arm bit reads 0 from the cycle after the last covered beat is corrupted. For select 01 that beat is the lower one; for selects 10 and 11 it is the upper one. A beat that was not corrupted never clears the arm bit.
- R6: With repeat on, every covered qualifying beat is corrupted and the ECC arm bit stays at 1 until software changes the control word.
- R7: On a qualifying beat with the parity arm bit set, the parity output is the inverse of the parity input, whatever the ECC arm bit and half select are. Without qualification or arming, parity passes through.
- R8: With repeat off, the parity arm bit reads 0 from the cycle after a qualifying upper beat was inverted. With repeat on, it stays at 1.
- R9: When software writes the control word in the same cycle as a self-clear, the value software wrote is what the register holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| wr_valid | input | 1 | Write beat valid |
| addr_match | input | 1 | External address comparator hit |
| beat_upper | input | 1 | 1 = beat is the upper 32-byte half |
| chk_in | input | 32 | Check bits from the encoder |
| par_in | input | 1 | Command/address parity from upstream |
| chk_out | output | 32 | Check bits after injection |
| par_out | output | 1 | Parity after injection |

## Verification
The hardest case to reach is the cycle in which a self-clear and a software control write land on the same clock edge. The bench builds it by issuing the control write in the very beat that completes an injection, and then reading the register back. Select 11 needs the same precision: the arm bit must survive the lower beat and drop only after the upper beat. The bench therefore reads the control word between the two beats. A stretch of random beats and control writes then compares every output against the reference model on every clock.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        HALF_NONE = 2'b00,
        HALF_LO   = 2'b01,
        HALF_HI   = 2'b10,
        HALF_BOTH = 2'b11
    } half_sel_e;

    // packed MSB first: bit4 par arm, bit3 ecc arm, bits2:1 half, bit0 repeat
    typedef struct packed {
        logic      arm_par;
        logic      arm_ecc;
        half_sel_e half;
        logic      repeat_en;
    } inj_ctrl_t;

endpackage

// File: rtl/inj_regfile.sv
module inj_regfile
    import ecc_inj_pkg::*;
#(
    parameter int                MASK_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'hF8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              clr_ecc,
    input  logic              clr_par,
    output logic [MASK_W-1:0] mask_o,
    output inj_ctrl_t         ctrl_o
);

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        inj_ctrl_t         ctrl;
    } rf_state_t;

    rf_state_t state_d, state_q;
    logic      mask_wr, ctrl_wr;

    assign mask_wr = reg_we && (reg_addr == MASK_OFS);
    assign ctrl_wr = reg_we && (reg_addr == CTRL_OFS);

    always_comb begin
        state_d = state_q;
        if (clr_ecc && !state_q.ctrl.repeat_en) begin
            state_d.ctrl.arm_ecc = 1'b0;
        end
        if (clr_par && !state_q.ctrl.repeat_en) begin
            state_d.ctrl.arm_par = 1'b0;
        end
        if (mask_wr) begin
            state_d.mask = reg_wdata[MASK_W-1:0];
        end
        if (ctrl_wr) begin
            state_d.ctrl = inj_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == MASK_OFS) begin
            reg_rdata[MASK_W-1:0] = state_q.mask;
        end else if (reg_addr == CTRL_OFS) begin
            reg_rdata[CTRL_W-1:0] = state_q.ctrl;
        end
    end

    assign mask_o = state_q.mask;
    assign ctrl_o = state_q.ctrl;

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(state_q.mask));

    // R5
    ecc_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ecc && !state_q.ctrl.repeat_en && !ctrl_wr) |=> !state_q.ctrl.arm_ecc);

    // R6
    repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ctrl.repeat_en && !ctrl_wr) |=> $stable(state_q.ctrl));

    // R9
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (state_q.ctrl == inj_ctrl_t'($past(reg_wdata[CTRL_W-1:0]))));

endmodule

// File: rtl/inj_beat_path.sv
module inj_beat_path
    import ecc_inj_pkg::*;
#(
    parameter int CHK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  inj_ctrl_t        ctrl,
    input  logic [CHK_W-1:0] mask,
    input  logic             wr_valid,
    input  logic             addr_match,
    input  logic             beat_upper,
    input  logic [CHK_W-1:0] chk_in,
    input  logic             par_in,
    output logic [CHK_W-1:0] chk_out,
    output logic             par_out,
    output logic             clr_ecc,
    output logic             clr_par
);

    logic qual, half_hit, ecc_hit, last_half, par_hit;

    always_comb begin
        qual      = wr_valid && addr_match;
        half_hit  = beat_upper ? ctrl.half[1] : ctrl.half[0];
        ecc_hit   = qual && ctrl.arm_ecc && half_hit;
        last_half = beat_upper || (ctrl.half == HALF_LO);
        par_hit   = qual && ctrl.arm_par;
        chk_out   = ecc_hit ? (chk_in ^ mask) : chk_in;
        par_out   = par_in ^ par_hit;
        clr_ecc   = ecc_hit && last_half;
        clr_par   = par_hit && beat_upper;
    end

    // R3
    no_arm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.arm_ecc && wr_valid && addr_match) |-> (chk_out == chk_in));

    // R4
    no_half_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.half == HALF_NONE) |-> (chk_out == chk_in));

    // R7
    par_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && addr_match && ctrl.arm_par) |-> (par_out != par_in));

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int                MASK_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'hF8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wr_valid,
    input  logic              addr_match,
    input  logic              beat_upper,
    input  logic [MASK_W-1:0] chk_in,
    input  logic              par_in,
    output logic [MASK_W-1:0] chk_out,
    output logic              par_out
);

    logic [MASK_W-1:0] mask_w;
    inj_ctrl_t         ctrl_w;
    logic              clr_ecc_w, clr_par_w;

    inj_regfile #(
        .MASK_W  (MASK_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .MASK_OFS(MASK_OFS),
        .CTRL_OFS(CTRL_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .clr_ecc  (clr_ecc_w),
        .clr_par  (clr_par_w),
        .mask_o   (mask_w),
        .ctrl_o   (ctrl_w)
    );

    inj_beat_path #(
        .CHK_W(MASK_W)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_w),
        .mask      (mask_w),
        .wr_valid  (wr_valid),
        .addr_match(addr_match),
        .beat_upper(beat_upper),
        .chk_in    (chk_in),
        .par_in    (par_in),
        .chk_out   (chk_out),
        .par_out   (par_out),
        .clr_ecc   (clr_ecc_w),
        .clr_par   (clr_par_w)
    );

endmodule

// File: tb/sim_ecc_inject_ctrl.sv
module sim_ecc_inject_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wr_valid = 1'b0;
    logic        addr_match = 1'b0;
    logic        beat_upper = 1'b0;
    logic [31:0] chk_in = '0;
    logic        par_in = 1'b0;
    logic [31:0] chk_out;
    logic        par_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state: m_ctrl bit0 repeat, 2:1 half, 3 ecc arm, 4 parity arm
    logic [31:0] m_mask = '0;
    logic [4:0]  m_ctrl = '0;

    always #5 clk = ~clk;

    ecc_inject_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
        .addr_match(addr_match), .beat_upper(beat_upper), .chk_in(chk_in),
        .par_in(par_in), .chk_out(chk_out), .par_out(par_out)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic we, input logic [7:0] addr,
                       input logic [31:0] wd, input logic wv, input logic am,
                       input logic up, input logic [31:0] chk, input logic par);
        logic        qual, hit, phit;
        logic [31:0] e_chk, e_rd;
        @(negedge clk);
        reg_we = we; reg_addr = addr; reg_wdata = wd;
        wr_valid = wv; addr_match = am; beat_upper = up;
        chk_in = chk; par_in = par;
        #1;
        qual  = wv && am;
        hit   = qual && m_ctrl[3] && (up ? m_ctrl[2] : m_ctrl[1]);
        phit  = qual && m_ctrl[4];
        e_chk = hit ? (chk ^ m_mask) : chk;
        e_rd  = (addr == 8'hF8) ? m_mask :
                (addr == 8'hFC) ? {27'd0, m_ctrl} : 32'd0;
        check(tag, "chk_out", chk_out, e_chk);
        check(tag, "par_out", {31'd0, par_out}, {31'd0, par ^ phit});
        check(tag, "reg_rdata", reg_rdata, e_rd);
        @(posedge clk);
        if (hit && (up || m_ctrl[2:1] == 2'b01) && !m_ctrl[0]) m_ctrl[3] = 1'b0;
        if (phit && up && !m_ctrl[0]) m_ctrl[4] = 1'b0;
        if (we && addr == 8'hF8) m_mask = wd;
        if (we && addr == 8'hFC) m_ctrl = wd[4:0];
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
        cyc(tag, 1'b1, a, d, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 1'b0);
    endtask

    task automatic beat(input string tag, input logic wv, input logic am, input logic up,
                        input logic [31:0] c, input logic p, input logic [7:0] rd);
        cyc(tag, 1'b0, rd, 32'd0, wv, am, up, c, p);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset values and pass-through
        beat("R1", 1, 1, 0, 32'hDEAD_BEEF, 1, 8'hF8);
        beat("R1", 1, 1, 1, 32'h0F0F_0F0F, 0, 8'hFC);
        // R2 register access
        wr("R2", 8'hF8, 32'h0000_00FF);
        wr("R2", 8'h40, 32'hFFFF_FFFF);
        beat("R2", 0, 0, 0, 32'h0, 0, 8'h40);
        beat("R2", 0, 0, 0, 32'h0, 0, 8'hF8);
        wr("R2", 8'hFC, 32'hFFFF_FFE2);
        beat("R2", 0, 0, 0, 32'h0, 0, 8'hFC);
        // R3 select set but ECC not armed
        wr("R3", 8'hFC, 32'h02);
        beat("R3", 1, 1, 0, 32'hAAAA_5555, 0, 8'hFC);
        // R3 armed but not qualified
        wr("R3", 8'hFC, 32'h0A);
        beat("R3", 1, 0, 0, 32'h1111_1111, 0, 8'hFC);
        beat("R3", 0, 1, 0, 32'h2222_2222, 0, 8'hFC);
        // R4 lower-only select: upper beat untouched, lower corrupted
        beat("R4", 1, 1, 1, 32'h3333_3333, 0, 8'hFC);
        beat("R4", 1, 1, 0, 32'h4444_4444, 0, 8'hFC);
        // R5 cleared after lower beat
        beat("R5", 1, 1, 0, 32'h5555_5555, 0, 8'hFC);
        // R4 upper-only select
        wr("R4", 8'hFC, 32'h0C);
        beat("R4", 1, 1, 0, 32'h6666_6666, 0, 8'hFC);
        beat("R4", 1, 1, 1, 32'h7777_7777, 0, 8'hFC);
        beat("R5", 1, 1, 1, 32'h7777_7777, 0, 8'hFC);
        // R5 both halves with uncorrectable pattern: survives lower beat
        wr("R4", 8'hF8, 32'h00FF_00FF);
        wr("R4", 8'hFC, 32'h0E);
        beat("R5", 1, 1, 0, 32'h8888_8888, 0, 8'hFC);
        beat("R5", 1, 1, 1, 32'h9999_9999, 0, 8'hFC);
        beat("R5", 1, 1, 0, 32'h9999_9999, 0, 8'hFC);
        // R4 select none while armed: no corruption, stays armed
        wr("R4", 8'hFC, 32'h08);
        beat("R4", 1, 1, 0, 32'hABCD_EF01, 0, 8'hFC);
        beat("R4", 1, 1, 1, 32'hABCD_EF01, 0, 8'hFC);
        // R6 repeat on lower half
        wr("R6", 8'hFC, 32'h0B);
        for (int i = 0; i < 4; i++) beat("R6", 1, 1, 0, 32'h0101_0101 * i, 0, 8'hFC);
        wr("R6", 8'hFC, 32'h0A);
        beat("R6", 1, 1, 0, 32'hCAFE_F00D, 0, 8'hFC);
        beat("R6", 1, 1, 0, 32'hCAFE_F00D, 0, 8'hFC);
        // R7 parity independent of ECC fields
        wr("R7", 8'hFC, 32'h10);
        beat("R7", 0, 1, 0, 32'h0, 1, 8'hFC);
        beat("R7", 1, 1, 0, 32'h0, 1, 8'hFC);
        beat("R8", 1, 1, 1, 32'h0, 0, 8'hFC);
        beat("R8", 1, 1, 1, 32'h0, 0, 8'hFC);
        // R8 repeat parity
        wr("R8", 8'hFC, 32'h11);
        for (int i = 0; i < 3; i++) beat("R8", 1, 1, 1, 32'h0, i[0], 8'hFC);
        // R9 software write in the self-clear cycle wins
        wr("R9", 8'hFC, 32'h0A);
        cyc("R9", 1, 8'hFC, 32'h1A, 1, 1, 0, 32'h5A5A_5A5A, 0);
        beat("R9", 0, 0, 0, 32'h0, 0, 8'hFC);
        wr("R9", 8'hFC, 32'h18);
        cyc("R9", 1, 8'hFC, 32'h00, 1, 1, 1, 32'h0, 1);
        beat("R9", 0, 0, 0, 32'h0, 0, 8'hFC);
        // R4 random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0)
                cyc("R4", 1, 8'hFC, {27'd0, r[8:4]}, r[9], r[10], r[11], $urandom, r[12]);
            else if (r[3:0] == 4'd1)
                cyc("R4", 1, 8'hF8, $urandom, r[9], r[10], r[11], $urandom, r[12]);
            else
                cyc("R4", 0, r[13] ? 8'hFC : 8'hF8, 32'd0, r[9], r[10], r[11], $urandom, r[12]);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule